// File: doc/BRIEF.md
# Symmetric FIR Coefficient RAM Loader

This block takes coefficient updates from a host over a three-wire serial link (data, bit clock, frame strobe) and stores them in a 256-entry coefficient RAM. A filter datapath reads that RAM through a second port. It gives a tap index and a rate selection, and the block folds the index onto the half-table that a symmetric, even-order impulse response needs. In the long configuration, 480 taps share 240 stored words held in one contiguous region. In the short configuration, 240 taps share 120 stored words split into two 60-word regions.

The serial inputs are sampled by the system clock and must already be synchronous to it. Each serial bit is taken on a rising edge of the bit clock, and the frame is committed on a rising edge of the strobe. A write to the RAM takes priority over a datapath read in the same cycle. Each write raises a mute request that lasts for one output-sample period, so the datapath can silence any coefficients that may have been corrupted. Words outside the permitted range are refused and set a sticky error flag. A per-address written flag shows which entries were never loaded.

Top module: `sym_coef_loader`

## Requirements
- R1: A committed frame writes the RAM only when its first received bit is 1. A frame whose first bit is 0 causes no write, no wr_strobe and no error.
- R2: Frame layout, first bit received first: bit 1 is the write flag, bits 2 and 3 are reserved and have no effect, bits 4 to 32 are the 29-bit two's-complement coefficient MSB first, and bits 33 to 40 are the RAM address MSB first.
- R3: Bits received after the 40th have no effect. A frame committed with fewer than 40 bits is dropped. The bit count restarts at every strobe rising edge.
- R4: A coefficient is accepted only when it lies between 0x18000000 (-2^27) and 0x07FFFFFF (2^27-1) inclusive. Any other word is not written, and range_err is set and stays set until reset.
- R5: An accepted frame raises wr_strobe for exactly one cycle, namely the cycle after the clock edge that sees the strobe rise. The RAM holds the new word for any read issued in the next cycle.
- R6: With rate_sel=0 (long mode, 480 taps), tap k reads address min(k, 479-k). Tap 0 maps to 0x00 and taps 239/240 map to 0xEF.
- R7: With rate_sel=1 (short mode, 240 taps), the folded index f=min(k, 239-k) maps to address f when f<60, and to 0x80+(f-60) otherwise.
- R8: A tap index at or beyond the tap count of the selected mode (480 or 240) is not served. rd_ack stays 0.
- R9: A read requested with rd_en at one clock edge returns rd_ack=1, rd_coef and rd_written after that edge, for one cycle. When rd_ack is 0, rd_coef and rd_written are 0.
- R10: A read requested in the cycle in which wr_strobe is high is not served. rd_ack is 0 for it.
- R11: After reset no address counts as written. Reading an unwritten address gives rd_written=0 and rd_coef=0, and reading a written one gives rd_written=1 and the stored word.
- R12: mute_req is high during the wr_strobe cycle and for SAMPLE_CYC further cycles after it, then falls. A new write restarts this period.
- R13: During and right after reset, rd_ack, rd_coef, rd_written, wr_strobe, mute_req and range_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock; data taken on its rising edge |
| ser_data | input | 1 | Serial frame data, first bit first |
| ser_latch | input | 1 | Frame strobe; rising edge commits the frame |
| rd_en | input | 1 | Datapath read request |
| rate_sel | input | 1 | 0 = long 480-tap layout, 1 = short 240-tap layout |
| tap_idx | input | 9 | Tap index to fold and read |
| rd_ack | output | 1 | Read served this cycle |
| rd_coef | output | 29 | Coefficient read |
| rd_written | output | 1 | Read address has been written since reset |
| wr_strobe | output | 1 | One-cycle pulse when the RAM is written |
| mute_req | output | 1 | Mute request to the filter datapath |
| range_err | output | 1 | Sticky flag for a refused out-of-range word |

## Verification
Directed frames first place the two extreme legal words at the edge and center addresses, and the words just outside them. This separates a correct two-bit sign check from an off-by-one range test. Reads of the fold break points (taps 59/60, 119/120, 179/180 in short mode, 239/240 and 479 in long mode) catch a wrong mirror point or a wrong second-region base. Frames with the write flag low, with reserved bits set, with 39 bits or with trailing extra bits show whether the decoder counts and positions fields correctly. A read timed onto the write pulse, and mute sampling at the last high and first low cycle, pin down precedence and the hold length. Random frames with random reads in both modes then compare every returned word and written flag against a bench model of the RAM.

// File: rtl/coefldr_pkg.sv
package coefldr_pkg;

    localparam int FRAME_BITS   = 40;
    localparam int COEF_W       = 29;
    localparam int ADDR_W       = 8;
    localparam int TAP_W        = 9;
    localparam int LONG_TAPS    = 480;
    localparam int SHORT_TAPS   = 240;
    localparam int SHORT_SEG    = 60;
    localparam int SHORT_HI     = 128;
    localparam int RAM_DEPTH    = 1 << ADDR_W;
    localparam int CNT_W        = $clog2(FRAME_BITS + 1);

    typedef enum logic {
        RATE_LONG  = 1'b0,
        RATE_SHORT = 1'b1
    } rate_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [COEF_W-1:0] data;
    } wr_req_t;

    // A 29-bit word lies in [-2^27, 2^27-1] exactly when its two top bits agree.
    function automatic logic coef_in_range(input logic [COEF_W-1:0] c);
        return c[COEF_W-1] == c[COEF_W-2];
    endfunction

endpackage

// File: rtl/coef_frame_rx.sv
module coef_frame_rx
    import coefldr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ser_clk,
    input  logic    ser_data,
    input  logic    ser_latch,
    output logic    wr_valid,
    output wr_req_t wr_req,
    output logic    range_err
);

    logic                  sclk_q;
    logic                  latch_q;
    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_W-1:0]      bit_cnt;
    logic                  sclk_rise;
    logic                  latch_rise;
    logic                  frame_full;
    logic                  frame_is_wr;
    logic [COEF_W-1:0]     frame_coef;
    logic [ADDR_W-1:0]     frame_addr;

    assign sclk_rise   = ser_clk & ~sclk_q;
    assign latch_rise  = ser_latch & ~latch_q;
    assign frame_full  = (bit_cnt == CNT_W'(FRAME_BITS));
    // first received bit ends at the top of the shift register
    assign frame_is_wr = shreg[FRAME_BITS-1];
    assign frame_coef  = shreg[ADDR_W +: COEF_W];
    assign frame_addr  = shreg[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            latch_q   <= 1'b0;
            shreg     <= '0;
            bit_cnt   <= '0;
            wr_valid  <= 1'b0;
            wr_req    <= '0;
            range_err <= 1'b0;
        end else begin
            sclk_q   <= ser_clk;
            latch_q  <= ser_latch;
            wr_valid <= 1'b0;
            if (latch_rise) begin
                bit_cnt <= '0;
                if (frame_full && frame_is_wr) begin
                    if (coef_in_range(frame_coef)) begin
                        wr_valid    <= 1'b1;
                        wr_req.addr <= frame_addr;
                        wr_req.data <= frame_coef;
                    end else begin
                        range_err <= 1'b1;
                    end
                end
            end else if (sclk_rise && !frame_full) begin
                shreg   <= {shreg[FRAME_BITS-2:0], ser_data};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assert_write_after_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> $past(ser_latch));

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);

    assert_written_word_legal_R4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_req.data[COEF_W-1] == wr_req.data[COEF_W-2]));

endmodule

// File: rtl/coef_tap_fold.sv
module coef_tap_fold
    import coefldr_pkg::*;
(
    input  logic [TAP_W-1:0]  tap,
    input  rate_e             rate,
    output logic [ADDR_W-1:0] addr,
    output logic              in_len
);

    localparam int LONG_HALF  = LONG_TAPS / 2;
    localparam int SHORT_HALF = SHORT_TAPS / 2;

    logic [TAP_W-1:0] fold_long;
    logic [TAP_W-1:0] fold_short;

    always_comb begin
        fold_long  = (tap < TAP_W'(LONG_HALF))  ? tap : TAP_W'(LONG_TAPS - 1) - tap;
        fold_short = (tap < TAP_W'(SHORT_HALF)) ? tap : TAP_W'(SHORT_TAPS - 1) - tap;
        if (rate == RATE_LONG) begin
            in_len = (tap < TAP_W'(LONG_TAPS));
            addr   = ADDR_W'(fold_long);
        end else begin
            in_len = (tap < TAP_W'(SHORT_TAPS));
            if (fold_short < TAP_W'(SHORT_SEG))
                addr = ADDR_W'(fold_short);
            else
                addr = ADDR_W'(SHORT_HI) + ADDR_W'(fold_short - TAP_W'(SHORT_SEG));
        end
    end

    always_comb begin
        if (in_len && rate == RATE_LONG)
            assert_long_region_R6: assert (addr < ADDR_W'(LONG_HALF));
        if (in_len && rate == RATE_SHORT)
            assert_short_region_R7: assert ((addr < ADDR_W'(SHORT_SEG)) ||
                ((addr >= ADDR_W'(SHORT_HI)) && (addr < ADDR_W'(SHORT_HI + SHORT_SEG))));
    end

endmodule

// File: rtl/coef_ram.sv
module coef_ram
    import coefldr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  wr_req_t           wr_req,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ack,
    output logic [COEF_W-1:0] rd_data,
    output logic              rd_written
);

    logic [COEF_W-1:0]    mem [RAM_DEPTH];
    logic [RAM_DEPTH-1:0] written;
    logic                 rd_go;

    // a host write wins the cycle; the datapath read is dropped
    assign rd_go = rd_en & ~wr_en;

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_req.addr] <= wr_req.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            written    <= '0;
            rd_ack     <= 1'b0;
            rd_data    <= '0;
            rd_written <= 1'b0;
        end else begin
            if (wr_en)
                written[wr_req.addr] <= 1'b1;
            rd_ack     <= rd_go;
            rd_written <= rd_go & written[rd_addr];
            rd_data    <= (rd_go && written[rd_addr]) ? mem[rd_addr] : '0;
        end
    end

    assert_write_blocks_read_R10: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !rd_ack);

    assert_ack_needs_request_R9: assert property (@(posedge clk) disable iff (rst)
        rd_ack |-> $past(rd_en));

    assert_idle_outputs_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_ack |-> (rd_data == '0 && !rd_written));

endmodule

// File: rtl/sym_coef_loader.sv
module sym_coef_loader
    import coefldr_pkg::*;
#(
    parameter int SAMPLE_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_latch,
    input  logic              rd_en,
    input  logic              rate_sel,
    input  logic [TAP_W-1:0]  tap_idx,
    output logic              rd_ack,
    output logic [COEF_W-1:0] rd_coef,
    output logic              rd_written,
    output logic              wr_strobe,
    output logic              mute_req,
    output logic              range_err
);

    localparam int MUTE_W = $clog2(SAMPLE_CYC + 1);

    wr_req_t           wr_req;
    logic [ADDR_W-1:0] fold_addr;
    logic              tap_ok;
    logic [MUTE_W-1:0] mute_cnt;
    rate_e             rate;

    assign rate = rate_e'(rate_sel);

    coef_frame_rx u_rx (
        .clk       (clk),
        .rst       (rst),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .wr_valid  (wr_strobe),
        .wr_req    (wr_req),
        .range_err (range_err)
    );

    coef_tap_fold u_fold (
        .tap    (tap_idx),
        .rate   (rate),
        .addr   (fold_addr),
        .in_len (tap_ok)
    );

    coef_ram u_ram (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_strobe),
        .wr_req     (wr_req),
        .rd_en      (rd_en & tap_ok),
        .rd_addr    (fold_addr),
        .rd_ack     (rd_ack),
        .rd_data    (rd_coef),
        .rd_written (rd_written)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mute_cnt <= '0;
        else if (wr_strobe)
            mute_cnt <= MUTE_W'(SAMPLE_CYC);
        else if (mute_cnt != '0)
            mute_cnt <= mute_cnt - 1'b1;
    end

    assign mute_req = wr_strobe | (mute_cnt != '0);

    assert_mute_during_write_R12: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> mute_req);

    assert_mute_after_write_R12: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> mute_req);

    assert_range_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        $past(range_err) |-> range_err);

endmodule

// File: tb/tb_sym_coef_loader.sv
module tb_sym_coef_loader;

    localparam int MUTE_N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_latch = 1'b0;
    logic        rd_en = 1'b0;
    logic        rate_sel = 1'b0;
    logic [8:0]  tap_idx = '0;
    logic        rd_ack;
    logic [28:0] rd_coef;
    logic        rd_written;
    logic        wr_strobe;
    logic        mute_req;
    logic        range_err;

    int vectors = 0;
    int fails = 0;

    logic [28:0] m_mem [256];
    logic        m_vld [256];
    logic        m_err = 1'b0;

    sym_coef_loader #(.SAMPLE_CYC(MUTE_N)) dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .rd_en(rd_en), .rate_sel(rate_sel),
        .tap_idx(tap_idx), .rd_ack(rd_ack), .rd_coef(rd_coef),
        .rd_written(rd_written), .wr_strobe(wr_strobe),
        .mute_req(mute_req), .range_err(range_err)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic legal_word(input logic [28:0] c);
        int v;
        v = c[28] ? int'(c) - (1 << 29) : int'(c);
        return (v >= -(1 << 27)) && (v <= (1 << 27) - 1);
    endfunction

    function automatic int map_tap(input int k, input logic short_mode);
        int f;
        if (!short_mode) begin
            if (k >= 480) return -1;
            return (k < 240) ? k : 479 - k;
        end
        if (k >= 240) return -1;
        f = (k < 120) ? k : 239 - k;
        return (f < 60) ? f : 128 + f - 60;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk); ser_data = b; ser_clk = 1'b0;
        @(negedge clk); ser_clk = 1'b1;
        @(negedge clk); ser_clk = 1'b0;
    endtask

    // host write; optional read collides with the write pulse
    task automatic host_write(input logic mode, input logic [1:0] rsvd,
                              input logic [28:0] coef, input logic [7:0] addr,
                              input int nbits, input logic collide, input int ctap,
                              input logic crate);
        logic [39:0] fr;
        logic        exp_wr;
        fr = {mode, rsvd, coef, addr};
        exp_wr = mode && (nbits >= 40) && legal_word(coef);
        for (int i = 0; i < nbits; i++)
            send_bit((i < 40) ? fr[39 - i] : 1'($urandom));
        @(negedge clk); ser_latch = 1'b1;
        @(negedge clk);
        check("R5 strobe pulse", 64'(wr_strobe), 64'(exp_wr));
        if (exp_wr) check("R12 mute in write cycle", 64'(mute_req), 64'd1);
        ser_latch = 1'b0;
        if (collide) begin
            rd_en = 1'b1; tap_idx = 9'(ctap); rate_sel = crate;
        end
        @(negedge clk);
        rd_en = 1'b0;
        check("R5 strobe single cycle", 64'(wr_strobe), 64'd0);
        if (collide) check("R10 read during write dropped", 64'(rd_ack), 64'(!exp_wr));
        if (exp_wr) begin
            m_mem[addr] = coef;
            m_vld[addr] = 1'b1;
        end
        if (mode && nbits >= 40 && !legal_word(coef)) m_err = 1'b1;
        check("R4 range_err", 64'(range_err), 64'(m_err));
    endtask

    task automatic do_read(input int k, input logic short_mode, input string req);
        int a;
        a = map_tap(k, short_mode);
        @(negedge clk); rd_en = 1'b1; tap_idx = 9'(k); rate_sel = short_mode;
        @(negedge clk); rd_en = 1'b0;
        if (a < 0) begin
            check({req, " R8 out-of-length ack"}, 64'(rd_ack), 64'd0);
            check({req, " R9 idle coef"}, 64'(rd_coef), 64'd0);
        end else begin
            check({req, " R9 ack"}, 64'(rd_ack), 64'd1);
            check({req, " R11 written flag"}, 64'(rd_written), 64'(m_vld[a]));
            check({req, " coef"}, 64'(rd_coef), m_vld[a] ? 64'(m_mem[a]) : 64'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 256; i++) begin m_mem[i] = '0; m_vld[i] = 1'b0; end
        repeat (3) @(negedge clk);
        check("R13 reset ack", 64'(rd_ack), 64'd0);
        check("R13 reset strobe", 64'(wr_strobe), 64'd0);
        check("R13 reset mute", 64'(mute_req), 64'd0);
        @(negedge clk); rst = 1'b0;
        check("R13 after reset outputs", 64'({rd_ack, rd_coef, rd_written, wr_strobe, mute_req, range_err}), 64'd0);
        do_read(0, 1'b0, "R11 unwritten");

        // extreme legal words at edge and center (R4, R6)
        host_write(1'b1, 2'b00, 29'h07FFFFFF, 8'h00, 40, 1'b0, 0, 1'b0);
        host_write(1'b1, 2'b00, 29'h18000000, 8'hEF, 40, 1'b0, 0, 1'b0);
        do_read(0,   1'b0, "R6 tap0");
        do_read(479, 1'b0, "R6 tap479");
        do_read(239, 1'b0, "R6 tap239");
        do_read(240, 1'b0, "R6 tap240");
        do_read(480, 1'b0, "R8 long 480");

        // short layout boundaries (R7)
        host_write(1'b1, 2'b00, 29'h00000A3B, 8'h3B, 40, 1'b0, 0, 1'b0);
        host_write(1'b1, 2'b00, 29'h1FFFF080, 8'h80, 40, 1'b0, 0, 1'b0);
        host_write(1'b1, 2'b00, 29'h000000BB, 8'hBB, 40, 1'b0, 0, 1'b0);
        do_read(59,  1'b1, "R7 tap59");
        do_read(60,  1'b1, "R7 tap60");
        do_read(119, 1'b1, "R7 tap119");
        do_read(120, 1'b1, "R7 tap120");
        do_read(179, 1'b1, "R7 tap179");
        do_read(180, 1'b1, "R7 tap180");
        do_read(0,   1'b1, "R7 tap0");
        do_read(240, 1'b1, "R8 short 240");

        // write flag low: nothing changes (R1)
        host_write(1'b0, 2'b00, 29'h00000123, 8'h00, 40, 1'b0, 0, 1'b0);
        do_read(0, 1'b0, "R1 no write");
        // out-of-range words (R4)
        host_write(1'b1, 2'b00, 29'h08000000, 8'h00, 40, 1'b0, 0, 1'b0);
        host_write(1'b1, 2'b00, 29'h17FFFFFF, 8'h01, 40, 1'b0, 0, 1'b0);
        do_read(0, 1'b0, "R4 refused");
        do_read(1, 1'b0, "R4 refused addr1");
        // reserved bits set (R2)
        host_write(1'b1, 2'b11, 29'h01234567, 8'h05, 40, 1'b0, 0, 1'b0);
        do_read(5, 1'b0, "R2 reserved");
        // short and long frames (R3)
        host_write(1'b1, 2'b00, 29'h00000777, 8'h06, 39, 1'b0, 0, 1'b0);
        do_read(6, 1'b0, "R3 short frame");
        host_write(1'b1, 2'b00, 29'h00000888, 8'h07, 44, 1'b0, 0, 1'b0);
        do_read(7, 1'b0, "R3 extra bits");

        // mute hold (R12): high until SAMPLE_CYC cycles after the pulse
        host_write(1'b1, 2'b00, 29'h00000999, 8'h08, 40, 1'b0, 0, 1'b0);
        repeat (MUTE_N - 1) @(negedge clk);
        check("R12 mute last cycle", 64'(mute_req), 64'd1);
        @(negedge clk);
        check("R12 mute released", 64'(mute_req), 64'd0);

        // collision (R10), then the retry is served
        host_write(1'b1, 2'b00, 29'h00000ABC, 8'h09, 40, 1'b1, 0, 1'b0);
        do_read(0, 1'b0, "R10 retry");

        // random frames and reads
        for (int it = 0; it < 70; it++) begin
            logic [28:0] c;
            logic        md;
            int          nb;
            c  = 29'($urandom);
            if (($urandom % 4) != 0) c[27] = c[28];
            md = (($urandom % 8) != 0);
            nb = (($urandom % 5) == 0) ? 40 + int'($urandom % 5) : 40;
            host_write(md, 2'($urandom), c, 8'($urandom), nb, 1'b0, 0, 1'b0);
            for (int r = 0; r < 4; r++) begin
                logic sm;
                sm = 1'($urandom);
                do_read(int'($urandom % (sm ? 250 : 490)), sm, "R6/R7 random");
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule